// File: doc/BRIEF.md
# Iterative 8-bit Multiply/Divide Unit

This block is the sequential multiply and divide engine for an 8-bit accumulator datapath. A request pulse captures two operand bytes, called A and B, together with an operation select. The unit then works through the operation over a fixed number of machine cycles. A clock-enable input marks each machine cycle. At the end, the unit presents new A and B bytes, a carry flag and an overflow flag, and raises a one-clock completion pulse.

Multiplication uses a shift-and-add array. Division uses a restoring array. Each array retires two operand bits per machine cycle, so both operations finish after four enabled cycles. The two results share one working register pair. For a multiply, the pair holds the high and low product bytes. For a divide, it holds the remainder and the quotient. The A result always comes from the low register and the B result from the high register.

Top module: `muldiv_unit`

## Requirements
- R1: While `rst` is high, and on the clock after it falls, `busy`, `done`, `a_out`, `b_out`, `cy_out` and `ov_out` are all 0.
- R2: For a multiply (`op_div`=0), the 16-bit unsigned product of A and B is split so that its low byte appears on `a_out` and its high byte on `b_out`.
- R3: After a multiply, `ov_out` is 1 exactly when the product is above FFh, that is, when the high byte on `b_out` is nonzero.
- R4: `cy_out` is 0 at every completion, for both operations.
- R5: For a divide (`op_div`=1) with a nonzero B, `a_out` is the unsigned quotient A/B, `b_out` is the remainder, and `ov_out` is 0.
- R6: For a divide with B equal to 00h, `ov_out` is 1 and `a_out`/`b_out` return the original A and B unchanged.
- R7: A start is accepted on a clock edge where `busy` is 0. `busy` rises on that edge. The operation then advances only on edges where `tick` is 1. `done` rises on the edge of the fourth such tick, and never earlier, however many clocks pass without a tick.
- R8: `done` is high for exactly one clock per operation. The outputs keep their values until the next completion.
- R9: A `start` that arrives while `busy` is 1 is ignored. The operation in flight completes with its captured operands and operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle enable |
| start | input | 1 | Request pulse, sampled while idle |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| a_out | output | 8 | Result A (product low byte or quotient) |
| b_out | output | 8 | Result B (product high byte or remainder) |
| cy_out | output | 1 | Carry flag result, always cleared |
| ov_out | output | 1 | Overflow flag result |

## Verification
`busy` is due one clock after the start edge. The results and `done` are due on the edge of the fourth `tick` counted after that, and `done` must be low again one clock later. The bench drives inputs and samples on falling edges. It raises `tick` for one clock at a time, with zero to two idle clocks in between. After each idle clock it confirms that `done` is still low, and it reads the results in the clock that follows the fourth tick. Operand inputs are inverted right after the start edge, and stray starts are injected during idle gaps. Any result that depends on late inputs therefore shows up as a mismatch.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {OP_MUL = 1'b0, OP_DIV = 1'b1} md_op_e;
endpackage

// File: rtl/md_mul_step.sv
module md_mul_step #(
  parameter int W = 8,
  parameter int K = 2
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] hi_s [K+1];
  logic [W-1:0] lo_s [K+1];

  assign hi_s[0] = hi_i;
  assign lo_s[0] = lo_i;

  for (genvar g = 0; g < K; g++) begin : g_bit
    logic [W:0] sum;
    assign sum = lo_s[g][0] ? ({1'b0, hi_s[g]} + {1'b0, mcand}) : {1'b0, hi_s[g]};
    assign hi_s[g+1] = sum[W:1];
    assign lo_s[g+1] = {sum[0], lo_s[g][W-1:1]};
  end

  assign hi_o = hi_s[K];
  assign lo_o = lo_s[K];
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
  parameter int W = 8,
  parameter int K = 2
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dsor,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] rem_s [K+1];
  logic [W-1:0] quo_s [K+1];

  assign rem_s[0] = rem_i;
  assign quo_s[0] = quo_i;

  for (genvar g = 0; g < K; g++) begin : g_bit
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;
    assign trial = {rem_s[g], quo_s[g][W-1]};
    assign diff  = trial - {1'b0, dsor};
    assign fits  = (trial >= {1'b0, dsor});
    assign rem_s[g+1] = fits ? diff[W-1:0] : trial[W-1:0];
    assign quo_s[g+1] = {quo_s[g][W-2:0], fits};
  end

  assign rem_o = rem_s[K];
  assign quo_o = quo_s[K];
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 8,
  parameter int K = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         cy_out,
  output logic         ov_out
);
  import muldiv_pkg::*;

  localparam int STEPS = W / K;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  md_op_e      op_q;
  logic        zero_q;
  logic [CW-1:0] step_cnt;
  logic [W-1:0] hi_q, lo_q, opnd_q;
  logic [W-1:0] mul_hi, mul_lo, div_hi, div_lo;
  logic [W-1:0] nxt_hi, nxt_lo;

  md_mul_step #(.W(W), .K(K)) u_mul (
    .hi_i(hi_q), .lo_i(lo_q), .mcand(opnd_q), .hi_o(mul_hi), .lo_o(mul_lo)
  );

  md_div_step #(.W(W), .K(K)) u_div (
    .rem_i(hi_q), .quo_i(lo_q), .dsor(opnd_q), .rem_o(div_hi), .quo_o(div_lo)
  );

  always_comb begin
    if (op_q == OP_MUL) begin
      nxt_hi = mul_hi;
      nxt_lo = mul_lo;
    end else if (zero_q) begin
      nxt_hi = hi_q;
      nxt_lo = lo_q;
    end else begin
      nxt_hi = div_hi;
      nxt_lo = div_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      op_q     <= OP_MUL;
      zero_q   <= 1'b0;
      step_cnt <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      opnd_q   <= '0;
      a_out    <= '0;
      b_out    <= '0;
      cy_out   <= 1'b0;
      ov_out   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy     <= 1'b1;
        op_q     <= md_op_e'(op_div);
        zero_q   <= op_div && (b_in == '0);
        step_cnt <= '0;
        hi_q     <= '0;
        lo_q     <= a_in;
        opnd_q   <= b_in;
      end else if (busy && tick) begin
        hi_q     <= nxt_hi;
        lo_q     <= nxt_lo;
        step_cnt <= step_cnt + 1'b1;
        if (step_cnt == LAST) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          a_out  <= nxt_lo;
          b_out  <= (op_q == OP_DIV && zero_q) ? opnd_q : nxt_hi;
          cy_out <= 1'b0;
          ov_out <= (op_q == OP_DIV) ? zero_q : (nxt_hi != '0);
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R4
  carry_clear_chk: assert property (@(posedge clk) disable iff (rst) done |-> !cy_out);
  // R3
  mul_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_MUL) |-> (ov_out == (b_out != '0)));
  // R5
  div_rem_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_DIV && !zero_q) |-> (!ov_out && b_out < opnd_q));
  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_DIV && zero_q) |-> (ov_out && b_out == '0));
  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> (busy && $stable(step_cnt)));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_q) && $stable(opnd_q)));
endmodule

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, start = 1'b0, op_div = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic busy, done, cy_out, ov_out;
  logic [7:0] a_out, b_out;
  int checks = 0, errors = 0;
  bit finished = 0;

  muldiv_unit uut (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .op_div(op_div),
    .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
    .a_out(a_out), .b_out(b_out), .cy_out(cy_out), .ov_out(ov_out)
  );

  always #5 clk = ~clk;

  // {op, a, b, expected a, expected b, expected ov}
  localparam int NV = 10;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 8'h0C, 8'h0A, 8'h78, 8'h00, 1'b0},
    {1'b0, 8'hFF, 8'hFF, 8'h01, 8'hFE, 1'b1},
    {1'b0, 8'h10, 8'h10, 8'h00, 8'h01, 1'b1},
    {1'b0, 8'h00, 8'h37, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hC8, 8'h07, 8'h1C, 8'h04, 1'b0},
    {1'b1, 8'hFF, 8'h01, 8'hFF, 8'h00, 1'b0},
    {1'b1, 8'h05, 8'h09, 8'h00, 8'h05, 1'b0},
    {1'b1, 8'h40, 8'h00, 8'h40, 8'h00, 1'b1},
    {1'b1, 8'hFF, 8'hFF, 8'h01, 8'h00, 1'b0},
    {1'b0, 8'h80, 8'h02, 8'h00, 8'h01, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [7:0] a, input logic [7:0] b,
                        input int gap, input bit intrude);
    @(negedge clk);
    op_div = op; a_in = a; b_in = b; start = 1'b1; tick = 1'b0;
    @(negedge clk);
    start = 1'b0; op_div = ~op; a_in = ~a; b_in = ~b;
    chk(busy == 1'b1, "R7", "busy after start", 16'(busy), 16'd1);
    for (int k = 0; k < 4; k++) begin
      for (int g = 0; g < gap; g++) begin
        start = intrude;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7", "done during idle clock", 16'(done), 16'd0);
      end
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (k < 3) chk(done == 1'b0, "R7", "done before fourth tick", 16'(done), 16'd0);
    end
    chk(done == 1'b1, "R7", "done after fourth tick", 16'(done), 16'd1);
  endtask

  task automatic check_pulse_end(input logic [7:0] ea, input logic [7:0] eb);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one clock wide", 16'(done), 16'd0);
    chk(a_out == ea && b_out == eb, "R8", "results held", {a_out, b_out}, {ea, eb});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "status in reset", {busy, done}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "status after reset", {busy, done}, 16'd0);
    chk(a_out == 0 && b_out == 0, "R1", "results after reset", {a_out, b_out}, 16'd0);
    chk(cy_out == 0 && ov_out == 0, "R1", "flags after reset", {cy_out, ov_out}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic        op;
      logic [7:0]  va, vb, ea, eb;
      logic        eov;
      {op, va, vb, ea, eb, eov} = VEC[i];
      run_op(op, va, vb, i % 3, 1'b0);
      if (op == 1'b0) begin
        chk(a_out == ea, "R2", "product low byte", 16'(a_out), 16'(ea));
        chk(b_out == eb, "R2", "product high byte", 16'(b_out), 16'(eb));
        chk(ov_out == eov, "R3", "multiply overflow", 16'(ov_out), 16'(eov));
      end else if (vb != 0) begin
        chk(a_out == ea, "R5", "quotient", 16'(a_out), 16'(ea));
        chk(b_out == eb, "R5", "remainder", 16'(b_out), 16'(eb));
        chk(ov_out == 1'b0, "R5", "divide overflow clear", 16'(ov_out), 16'd0);
      end else begin
        chk(a_out == ea && b_out == eb, "R6", "zero divisor keeps operands",
            {a_out, b_out}, {ea, eb});
        chk(ov_out == 1'b1, "R6", "zero divisor overflow", 16'(ov_out), 16'd1);
      end
      chk(cy_out == 1'b0, "R4", "carry cleared", 16'(cy_out), 16'd0);
      check_pulse_end(ea, eb);
    end

    // R9: stray starts during the operation carry inverted operands and op
    run_op(1'b0, 8'h0C, 8'h0A, 2, 1'b1);
    chk(a_out == 8'h78 && b_out == 8'h00, "R9", "start while busy ignored",
        {a_out, b_out}, 16'h7800);
    check_pulse_end(8'h78, 8'h00);

    // R8: ticks with no start leave results and done untouched
    for (int k = 0; k < 6; k++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    chk(done == 0 && busy == 0, "R8", "no completion without start", {done, busy}, 16'd0);
    chk(a_out == 8'h78 && b_out == 8'h00, "R8", "results held while idle",
        {a_out, b_out}, 16'h7800);

    // R1: reset in the middle of an operation
    @(negedge clk);
    op_div = 1'b0; a_in = 8'h33; b_in = 8'h44; start = 1'b1;
    @(negedge clk);
    start = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    tick = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "mid-operation reset status", {busy, done}, 16'd0);
    chk(a_out == 0 && b_out == 0 && ov_out == 0, "R1", "mid-operation reset results",
        {a_out, b_out}, 16'd0);
    rst = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule